// File: doc/BRIEF.md
# Interrupt Pending/Active State Tracker

This block holds the service state of a set of peripheral interrupt lines. Each line is always in one of four states: idle, waiting for service, in service, or in service with a fresh request queued behind it. A line is set up at build time as either level-sensitive or pulse-type, and the two kinds move between states by different rules. Requests come from the raw line inputs, from software set strobes and from a software trigger port that takes a line number. Software can also withdraw a waiting request.

The core's exception logic drives an event port. It reports that the handler for a given line has been entered, or that it has returned. The tracker then updates the line's state. It presents the waiting and in-service vectors, and a single request flag that is raised while any enabled line is waiting. Priority selection, vector fetch and nesting sit outside the block. All inputs are assumed synchronous to `clk`.

Top module: `irq_state_tracker`

## Requirements
- R1: A level-sensitive line whose input is high while the line is not in service becomes waiting on the next clock edge, and it stays waiting.
- R2: A pulse-type line becomes waiting when its input is high and was low at the previous clock edge. The edge is judged against a registered copy of the input, and that copy resets low. An input that is held high does not raise a new request.
- R3: A set strobe, or a trigger write with `trig_valid` high and `trig_idx` equal to a line number, makes that line waiting. A trigger write with `trig_idx` of `NUM_LINES` or more changes nothing.
- R4: A line becomes waiting whatever its enable bit is. `irq_req_o` is high exactly when some line is both waiting and enabled. Enable bits are set by `en_set` and cleared by `en_clr`, and when both strike the same line in one cycle, set wins.
- R5: An entry event (`evt_valid` high, `evt_return` low, `evt_idx` naming the line) on a waiting line clears its waiting bit and sets its in-service bit on the next edge. An entry event on a line that is not waiting is ignored.
- R6: On a return event for a level-sensitive line, the input is sampled in that cycle. If it is high, the line becomes waiting; if it is low, the line becomes idle.
- R7: A rising edge on a pulse-type line that is in service makes it in-service-and-waiting. A return event then leaves it waiting only. A return with no such edge during service leaves it idle.
- R8: A return event (`evt_return` high) for a line that is not in service changes nothing.
- R9: A clear strobe on a level-sensitive line does nothing while its input is high. With the input low, it clears the waiting bit.
- R10: A clear strobe on a pulse-type line clears its waiting bit and never touches its in-service bit. Waiting goes to idle, in-service-and-waiting goes to in-service, and in-service stays in-service.
- R11: When a set strobe and a clear strobe reach the same line in the same cycle, the line ends up waiting.
- R12: After reset, every line is idle, every enable bit is clear and `irq_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| irq_lines | input | NUM_LINES | Raw peripheral interrupt inputs |
| swi_set | input | NUM_LINES | Software set-waiting strobes |
| swi_clr | input | NUM_LINES | Software clear-waiting strobes |
| trig_valid | input | 1 | Software trigger write strobe |
| trig_idx | input | IDX_W | Line number for the trigger write |
| en_set | input | NUM_LINES | Enable-bit set strobes |
| en_clr | input | NUM_LINES | Enable-bit clear strobes |
| evt_valid | input | 1 | Core exception event strobe |
| evt_return | input | 1 | 0 = handler entry, 1 = handler return |
| evt_idx | input | IDX_W | Line number of the event |
| pend_o | output | NUM_LINES | Waiting bit per line |
| act_o | output | NUM_LINES | In-service bit per line |
| irq_req_o | output | 1 | An enabled line is waiting |

## Verification
Every state bit reaches a port, so a wrong next-state choice shows on `pend_o` or `act_o` one edge after the event that caused it. The bench samples there. The costly mistakes are the ones where level and pulse rules get mixed up. Examples are a held-high pulse line that keeps re-requesting, a level line that drops its request at return while its input is still high, and a clear strobe that withdraws a level request whose input is still high. Each of these gives a wrong bit in that next cycle. A lost enable or a wrong trigger decode shows on `irq_req_o` or `pend_o` in the cycle after the strobe.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
   // Meaning of the core event kind bit.
   typedef enum logic {
      EVT_ENTER  = 1'b0,
      EVT_RETURN = 1'b1
   } evt_kind_e;
endpackage

// File: rtl/irq_idx_decode.sv
// Turns a qualified line number into a one-hot strobe; numbers past the last line give zero.
module irq_idx_decode #(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 4
) (
   input  logic                 valid_i,
   input  logic [IDX_W-1:0]     idx_i,
   output logic [NUM_LINES-1:0] hot_o
);
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
      assign hot_o[i] = valid_i && (idx_i == IDX_W'(i));
   end
endmodule

// File: rtl/irq_line_state.sv
// State of one line: waiting (pend) and in-service (act) bits.
module irq_line_state #(
   parameter bit IS_PULSE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   input  logic sw_set_i,
   input  logic sw_clr_i,
   input  logic entry_i,
   input  logic return_i,
   output logic pend_o,
   output logic act_o
);
   logic pend_q, act_q;
   logic pend_n, act_n;
   logic entry_ok, ret_ok;

   assign entry_ok = entry_i & pend_q;
   assign ret_ok   = return_i & act_q;
   assign act_n    = entry_ok | (act_q & ~ret_ok);

   if (IS_PULSE) begin : g_pulse
      logic sig_q;
      logic rise_w;
      logic keep_w;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sig_q <= 1'b0;
         else        sig_q <= sig_i;
      end

      assign rise_w = sig_i & ~sig_q;
      assign keep_w = pend_q & ~entry_ok & ~sw_clr_i;
      assign pend_n = keep_w | rise_w | sw_set_i;

      // R7: a queued request survives the return as plain waiting
      a_r7_ret_keeps_pend: assert property (@(posedge clk) disable iff (!rst_n)
         (return_i && act_q && pend_q && !sw_clr_i) |=> (pend_q && !act_q));
   end else begin : g_level
      logic keep_w;
      assign keep_w = pend_q & ~entry_ok & ~(sw_clr_i & ~sig_i);
      assign pend_n = keep_w | (sig_i & ~act_n) | sw_set_i;

      // R9: clear is blocked while the input is still high
      a_r9_clr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_clr_i && sig_i && pend_q && !entry_i) |=> pend_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         pend_q <= pend_n;
         act_q  <= act_n;
      end
   end

   assign pend_o = pend_q;
   assign act_o  = act_q;

   // R1: a new request always has a visible cause one cycle earlier
   a_r1_pend_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(sig_i | sw_set_i));
   // R5: entry on a waiting line puts it in service
   a_r5_entry_activates: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_i && pend_q) |=> act_q);
   // R8: return on an idle line leaves it out of service
   a_r8_ret_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (return_i && !act_q && !entry_i) |=> !act_q);
   // R10: clearing never ends service
   a_r10_clr_keeps_act: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr_i && act_q && !return_i) |=> act_q);
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
   parameter int                   NUM_LINES  = 8,
   parameter int                   IDX_W      = $clog2(NUM_LINES) + 1,
   parameter logic [NUM_LINES-1:0] PULSE_MASK = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic [NUM_LINES-1:0] swi_set,
   input  logic [NUM_LINES-1:0] swi_clr,
   input  logic                 trig_valid,
   input  logic [IDX_W-1:0]     trig_idx,
   input  logic [NUM_LINES-1:0] en_set,
   input  logic [NUM_LINES-1:0] en_clr,
   input  logic                 evt_valid,
   input  logic                 evt_return,
   input  logic [IDX_W-1:0]     evt_idx,
   output logic [NUM_LINES-1:0] pend_o,
   output logic [NUM_LINES-1:0] act_o,
   output logic                 irq_req_o
);
   import irq_trk_pkg::*;

   localparam int MIN_IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   if (NUM_LINES < 1) begin : g_bad_lines
      $error("irq_state_tracker: NUM_LINES must be at least 1");
   end
   if (IDX_W < MIN_IDX_W) begin : g_bad_idx
      $error("irq_state_tracker: IDX_W too narrow for NUM_LINES");
   end

   logic [NUM_LINES-1:0] trig_hot, evt_hot, entry_v, return_v, set_v;
   logic [NUM_LINES-1:0] en_q;
   evt_kind_e            evt_kind;

   assign evt_kind = evt_kind_e'(evt_return);

   irq_idx_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_trig_dec (
      .valid_i (trig_valid),
      .idx_i   (trig_idx),
      .hot_o   (trig_hot)
   );

   irq_idx_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_evt_dec (
      .valid_i (evt_valid),
      .idx_i   (evt_idx),
      .hot_o   (evt_hot)
   );

   assign entry_v  = (evt_kind == EVT_ENTER)  ? evt_hot : '0;
   assign return_v = (evt_kind == EVT_RETURN) ? evt_hot : '0;
   assign set_v    = swi_set | trig_hot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= (en_q & ~en_clr) | en_set;
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      irq_line_state #(.IS_PULSE(PULSE_MASK[i])) u_line (
         .clk      (clk),
         .rst_n    (rst_n),
         .sig_i    (irq_lines[i]),
         .sw_set_i (set_v[i]),
         .sw_clr_i (swi_clr[i]),
         .entry_i  (entry_v[i]),
         .return_i (return_v[i]),
         .pend_o   (pend_o[i]),
         .act_o    (act_o[i])
      );
   end

   assign irq_req_o = |(pend_o & en_q);

   // R3: one trigger write names at most one line
   a_r3_trig_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trig_hot));
   // R5: one event touches at most one line
   a_r5_evt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(entry_v | return_v));
   // R4: set strobe enables a waiting line's request next cycle
   a_r4_en_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|(en_set & pend_o & ~swi_clr & ~entry_v)) |=> irq_req_o);
endmodule

// File: tb/irq_state_tracker_tb_top.sv
module irq_state_tracker_tb_top;
   localparam int N = 8;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq_lines = '0, swi_set = '0, swi_clr = '0, en_set = '0, en_clr = '0;
   logic         trig_valid = 1'b0, evt_valid = 1'b0, evt_return = 1'b0;
   logic [W-1:0] trig_idx = '0, evt_idx = '0;
   logic [N-1:0] pend_o, act_o;
   logic         irq_req_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   irq_state_tracker #(.NUM_LINES(N), .IDX_W(W), .PULSE_MASK(8'hF0)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .swi_set(swi_set), .swi_clr(swi_clr),
      .trig_valid(trig_valid), .trig_idx(trig_idx), .en_set(en_set), .en_clr(en_clr),
      .evt_valid(evt_valid), .evt_return(evt_return), .evt_idx(evt_idx),
      .pend_o(pend_o), .act_o(act_o), .irq_req_o(irq_req_o)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic evt(input bit ret, input int idx);
      evt_valid = 1'b1; evt_return = ret; evt_idx = W'(idx);
      step();
      evt_valid = 1'b0; evt_return = 1'b0;
   endtask

   task automatic clr(input int idx);
      swi_clr[idx] = 1'b1; step(); swi_clr[idx] = 1'b0;
   endtask

   task automatic t_reset();
      chk(32'(pend_o), 0, "R12 pend after reset");
      chk(32'(act_o), 0, "R12 act after reset");
      chk(32'(irq_req_o), 0, "R12 req after reset");
   endtask

   task automatic t_level();
      irq_lines[0] = 1'b1; step();
      chk(32'(pend_o[0]), 1, "R1 level high sets pend");
      chk(32'(irq_req_o), 0, "R4 disabled line no req");
      en_set[0] = 1'b1; step(); en_set[0] = 1'b0;
      chk(32'(irq_req_o), 1, "R4 enabled pend gives req");
      evt(1'b0, 0);
      chk(32'({act_o[0], pend_o[0]}), 2, "R5 entry moves to active");
      step();
      chk(32'(pend_o[0]), 0, "R1 no pend while active");
      evt(1'b1, 0);
      chk(32'({act_o[0], pend_o[0]}), 1, "R6 return with input high");
      evt(1'b0, 0);
      irq_lines[0] = 1'b0;
      evt(1'b1, 0);
      chk(32'({act_o[0], pend_o[0]}), 0, "R6 return with input low");
      en_clr[0] = 1'b1; step(); en_clr[0] = 1'b0;
      evt(1'b0, 2);
      chk(32'(act_o[2]), 0, "R5 entry on idle line ignored");
      evt(1'b1, 2);
      chk(32'({act_o[2], pend_o[2]}), 0, "R8 return on idle line ignored");
   endtask

   task automatic t_pulse();
      irq_lines[4] = 1'b1; step();
      chk(32'(pend_o[4]), 1, "R2 rising edge sets pend");
      evt(1'b0, 4);
      chk(32'({act_o[4], pend_o[4]}), 2, "R5 pulse entry");
      step();
      chk(32'(pend_o[4]), 0, "R2 held high no new request");
      irq_lines[4] = 1'b0; step();
      irq_lines[4] = 1'b1; step();
      chk(32'({act_o[4], pend_o[4]}), 3, "R7 pulse during service");
      evt(1'b1, 4);
      chk(32'({act_o[4], pend_o[4]}), 1, "R7 return leaves pending");
      evt(1'b0, 4);
      evt(1'b1, 4);
      chk(32'({act_o[4], pend_o[4]}), 0, "R7 return without pulse idle");
      irq_lines[4] = 1'b0; step();
   endtask

   task automatic t_clr_level();
      irq_lines[1] = 1'b1; step();
      clr(1);
      chk(32'(pend_o[1]), 1, "R9 clear blocked while high");
      irq_lines[1] = 1'b0; step();
      chk(32'(pend_o[1]), 1, "R1 level pend latched");
      clr(1);
      chk(32'(pend_o[1]), 0, "R9 clear with input low");
   endtask

   task automatic t_clr_pulse();
      irq_lines[5] = 1'b1; step(); irq_lines[5] = 1'b0;
      clr(5);
      chk(32'({act_o[5], pend_o[5]}), 0, "R10 pend to idle");
      irq_lines[5] = 1'b1; step(); irq_lines[5] = 1'b0;
      evt(1'b0, 5);
      irq_lines[5] = 1'b1; step(); irq_lines[5] = 1'b0;
      chk(32'({act_o[5], pend_o[5]}), 3, "R7 active and pending");
      clr(5);
      chk(32'({act_o[5], pend_o[5]}), 2, "R10 act+pend to act");
      clr(5);
      chk(32'({act_o[5], pend_o[5]}), 2, "R10 act stays act");
      evt(1'b1, 5);
      chk(32'({act_o[5], pend_o[5]}), 0, "R10 cleanup return idle");
   endtask

   task automatic t_sw();
      swi_set[2] = 1'b1; step(); swi_set[2] = 1'b0;
      chk(32'(pend_o), 32'h04, "R3 set strobe");
      trig_valid = 1'b1; trig_idx = 4'd3; step();
      chk(32'(pend_o), 32'h0C, "R3 trigger index 3");
      trig_idx = 4'd8; step();
      chk(32'(pend_o), 32'h0C, "R3 trigger index 8 ignored");
      trig_idx = 4'd15; step(); trig_valid = 1'b0;
      chk(32'(pend_o), 32'h0C, "R3 trigger index 15 ignored");
      swi_set[6] = 1'b1; swi_clr[6] = 1'b1; step();
      swi_set[6] = 1'b0; swi_clr[6] = 1'b0;
      chk(32'(pend_o[6]), 1, "R11 set beats clear");
      chk(32'(irq_req_o), 0, "R4 pend without enable");
      en_set[3] = 1'b1; en_clr[3] = 1'b1; step();
      en_set[3] = 1'b0; en_clr[3] = 1'b0;
      chk(32'(irq_req_o), 1, "R4 enable set beats clear");
      en_clr[3] = 1'b1; step(); en_clr[3] = 1'b0;
      chk(32'(irq_req_o), 0, "R4 enable cleared");
      swi_clr = 8'h4C; step(); swi_clr = '0;
      chk(32'(pend_o), 0, "R10 bulk clear");
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_level();
      t_pulse();
      t_clr_level();
      t_clr_pulse();
      t_sw();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule